// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block collects single-cycle event pulses from a serial storage link layer into sticky status bits and drives one registered interrupt line to the processor. The sources are a command-completion event on bit 0, a critical error on bit 1, a general error on bit 2, a link error on bit 3, and further error sources on the bits above. A status bit stays set until software acknowledges it. The interrupt line is raised only when a pending bit is not masked and the master enable is on.

Software reaches three registers through a small write/read port with a 2-bit select. To acknowledge, software writes the status register with a 1 in every bit it wants to keep and a 0 in every bit it has handled. A 1 in a mask bit blocks that source from the interrupt line. One bit of a separate enable register gates the whole aggregated source. The number of implemented status and mask bits is a parameter: 11 for the older variant and 12 for the newer one.

Top module: `irqagg_top`

## Requirements
- R1: After reset the status register reads 0, the mask reads all ones over the implemented width (0xFFF when the width is 12, 0x7FF when it is 11), the enable register reads 0, and `irq_o` is 0.
- R2: A 1 on `evt_i[i]` during a clock edge sets status bit i at that edge, whether or not bit i is masked. The bit stays set until a status write clears it.
- R3: A status write (select 0) clears every status bit that is written with 0 and leaves every bit written with 1 unchanged. A write of all zeros clears every pending bit.
- R4: When an event arrives in the same cycle as a write that would clear its bit, the bit ends up set.
- R5: A mask write (select 1) stores the low implemented bits of the write data. Read data bits above the implemented width are 0 for both status and mask.
- R6: An enable write (select 2) stores only data bit 11, the master enable, and the register reads back with every other bit 0.
- R7: `irq_o` is a register. In the cycle after the master enable is 1 and some status bit is set with its mask bit 0, it is 1. In the cycle after that condition is false, it is 0.
- R8: With the width parameter set to 11, only bits 10..0 of status and mask exist. Events and writes act on those bits alone.
- R9: Select 3 reads 0, and a write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| evt_i | input | STAT_W | Event pulses. Bit 0 is command completion, bit 1 critical error, bit 2 general error, bit 3 link error |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 enable, 3 none |
| cfg_wdata_i | input | DATA_W | Write data |
| cfg_rdata_o | output | DATA_W | Read data of the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Register writes and event pulses take effect at the clock edge they are sampled on, so the read port shows the new status, mask or enable value in the half cycle that follows. `irq_o` is computed from those registered values and lags them by one more edge. The bench drives and samples on falling edges. After each stimulus it reads the registers right away. It checks `irq_o` first at that same point, where it must still show the old value, and again one falling edge later, where it must show the new one. This is how the one-cycle lag is confirmed.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Register select codes of the configuration port
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ENAB = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irqagg_rst_sync.sv
module irqagg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/irqagg_status.sv
module irqagg_status #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  // One sticky cell per source; an event beats a clearing write
  for (genvar b = 0; b < W; b++) begin : g_cell
    logic hold;

    always_comb begin
      hold = stat_q[b];
      if (ack_we_i) begin
        hold = stat_q[b] & keep_i[b];
      end
      stat_d[b] = hold | evt_i[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[b] <= 1'b0;
      end else begin
        stat_q[b] <= stat_d[b];
      end
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic         en_we_i,
  input  logic         en_wdata_i,
  output logic [W-1:0] mask_o,
  output logic         en_o
);

  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         en_q;
  logic         en_d;

  always_comb begin
    mask_d = mask_q;
    en_d   = en_q;
    if (mask_we_i) begin
      mask_d = mask_wdata_i;
    end
    if (en_we_i) begin
      en_d = en_wdata_i;
    end
  end

  // Mask resets to every source blocked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (mask_we_i) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (en_we_i) begin
      en_q <= en_d;
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;

endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic         irq_o
);

  logic [W-1:0] live;
  logic         irq_d;
  logic         irq_q;

  always_comb begin
    live  = stat_i & ~mask_i;
    irq_d = en_i & (|live);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
  parameter int STAT_W = 12,
  parameter int EN_BIT = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              irq_o
);

  import irqagg_pkg::*;

  logic              rst_n_sync;
  reg_sel_e          sel;
  logic              stat_we;
  logic              mask_we;
  logic              en_we;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  logic              en_q;

  irqagg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  assign sel = reg_sel_e'(cfg_sel_i);

  always_comb begin
    stat_we = 1'b0;
    mask_we = 1'b0;
    en_we   = 1'b0;
    if (cfg_we_i) begin
      unique case (sel)
        SEL_STAT: stat_we = 1'b1;
        SEL_MASK: mask_we = 1'b1;
        SEL_ENAB: en_we   = 1'b1;
        default:  ;
      endcase
    end
  end

  irqagg_status #(.W(STAT_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .evt_i    (evt_i),
    .ack_we_i (stat_we),
    .keep_i   (cfg_wdata_i[STAT_W-1:0]),
    .stat_o   (stat_q)
  );

  irqagg_ctrl #(.W(STAT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_sync),
    .mask_we_i    (mask_we),
    .mask_wdata_i (cfg_wdata_i[STAT_W-1:0]),
    .en_we_i      (en_we),
    .en_wdata_i   (cfg_wdata_i[EN_BIT]),
    .mask_o       (mask_q),
    .en_o         (en_q)
  );

  irqagg_line #(.W(STAT_W)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .stat_i (stat_q),
    .mask_i (mask_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  // Read mux, unimplemented bits read zero
  always_comb begin
    cfg_rdata_o = '0;
    unique case (sel)
      SEL_STAT: cfg_rdata_o[STAT_W-1:0] = stat_q;
      SEL_MASK: cfg_rdata_o[STAT_W-1:0] = mask_q;
      SEL_ENAB: cfg_rdata_o[EN_BIT]     = en_q;
      default:  cfg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic [W-1:0] evt_i,
  input logic         stat_we,
  input logic [W-1:0] wdata,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] mask_q,
  input logic         en_q,
  input logic         irq_o
);

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stat_we && (evt_i == '0)) |=> (stat_q == ($past(stat_q) & $past(wdata)))); // R3

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_q |=> !irq_o); // R7

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_q && (|(stat_q & ~mask_q))) |=> irq_o); // R7

  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|(stat_q & ~mask_q)) |=> !irq_o); // R7

endmodule

bind irqagg_top irqagg_chk #(.W(STAT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n_sync),
  .evt_i   (evt_i),
  .stat_we (stat_we),
  .wdata   (cfg_wdata_i[STAT_W-1:0]),
  .stat_q  (stat_q),
  .mask_q  (mask_q),
  .en_q    (en_q),
  .irq_o   (irq_o)
);

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;
  localparam logic [31:0] WIDE = 32'hFFF;
  localparam logic [31:0] NARR = 32'h7FF;

  logic        clk;
  logic        rst_n;
  logic [11:0] evt;
  logic        we;
  logic [1:0]  sel;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] rdata_n;
  logic        irq;
  logic        irq_n;

  int n_chk;
  int n_bad;

  irqagg_top #(.STAT_W(12), .EN_BIT(11), .DATA_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cfg_we_i(we),
    .cfg_sel_i(sel), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .irq_o(irq)
  );

  irqagg_top #(.STAT_W(11), .EN_BIT(11), .DATA_W(32)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt[10:0]), .cfg_we_i(we),
    .cfg_sel_i(sel), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_n), .irq_o(irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // One clock of stimulus; returns at the falling edge after it
  task automatic step(input logic w, input logic [1:0] s,
                      input logic [31:0] d, input logic [11:0] e);
    we = w; sel = s; wdata = d; evt = e;
    @(negedge clk);
    we = 1'b0; evt = '0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v,
                    output logic [31:0] vn);
    sel = s;
    #1;
    v  = rdata;
    vn = rdata_n;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] v, vn, p;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; evt = '0; we = 1'b0; sel = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v, vn); chk("R1", "status", v, 0); chk("R1", "status narrow", vn, 0);
    rd(2'd1, v, vn); chk("R1", "mask", v, WIDE); chk("R1", "mask narrow", vn, NARR);
    rd(2'd2, v, vn); chk("R1", "enable", v, 0);
    chk("R1", "irq", {31'd0, irq}, 0);

    // R5 / R8 mask width
    step(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
    rd(2'd1, v, vn); chk("R5", "mask wide", v, WIDE); chk("R8", "mask narrow", vn, NARR);

    // R6 enable register keeps only bit 11
    step(1'b1, 2'd2, 32'hFFFF_FFFF, '0);
    rd(2'd2, v, vn); chk("R6", "enable all ones", v, 32'h800);
    step(1'b1, 2'd2, 32'hFFFF_F7FF, '0);
    rd(2'd2, v, vn); chk("R6", "enable bit11 low", v, 0);

    // Sweep: unmasked bit i, event on bit j
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        step(1'b1, 2'd0, 32'h0, '0);
        step(1'b1, 2'd1, ~(32'd1 << i), '0);
        step(1'b1, 2'd2, 32'h800, '0);
        @(negedge clk);
        chk("R7", "idle irq", {31'd0, irq}, 0);
        step(1'b0, 2'd0, 32'h0, 12'(1 << j));
        rd(2'd0, v, vn);
        chk("R2", "event sets", v, 32'd1 << j);
        chk("R8", "narrow event", vn, (32'd1 << j) & NARR);
        chk("R7", "irq lags", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R7", "irq follows", {31'd0, irq}, (i == j) ? 32'd1 : 32'd0);
        step(1'b1, 2'd0, ~(32'd1 << j), '0);
        rd(2'd0, v, vn);
        chk("R3", "ack clears", v, 0);
        @(negedge clk);
        chk("R7", "irq drops", {31'd0, irq}, 0);
      end
    end

    // R3 acknowledge patterns on all-set status
    for (int k = 0; k < 16; k++) begin
      p = (k * 32'h9E37_79B9) ^ (k << 3);
      step(1'b0, 2'd0, 32'h0, 12'hFFF);
      step(1'b1, 2'd0, p, '0);
      rd(2'd0, v, vn);
      chk("R3", "keep pattern", v, p & WIDE);
      chk("R8", "keep pattern narrow", vn, p & NARR);
    end
    step(1'b0, 2'd0, 32'h0, 12'hFFF);
    step(1'b1, 2'd0, 32'h0, '0);
    rd(2'd0, v, vn); chk("R3", "write zero clears all", v, 0);

    // R4 event against clearing write
    step(1'b0, 2'd0, 32'h0, 12'h0F0);
    step(1'b1, 2'd0, 32'h0, 12'h009);
    rd(2'd0, v, vn); chk("R4", "event beats clear", v, 32'h009);

    // R9 select 3 reads zero and writes nothing
    rd(2'd3, v, vn); chk("R9", "read sel3", v, 0);
    step(1'b1, 2'd3, 32'h0, '0);
    rd(2'd0, v, vn); chk("R9", "status untouched", v, 32'h009);
    rd(2'd1, v, vn); chk("R9", "mask untouched", v, WIDE & ~32'h800);

    // R2 sticky while masked, then unmask; R6 master enable gates
    step(1'b1, 2'd1, 32'hFFF, '0);
    step(1'b1, 2'd2, 32'h800, '0);
    @(negedge clk);
    chk("R2", "masked no irq", {31'd0, irq}, 0);
    rd(2'd0, v, vn); chk("R2", "still set while masked", v, 32'h009);
    step(1'b1, 2'd1, 32'hFF7, '0);
    @(negedge clk);
    chk("R7", "unmask raises", {31'd0, irq}, 1);
    step(1'b1, 2'd2, 32'h0, '0);
    @(negedge clk);
    chk("R6", "enable off lowers", {31'd0, irq}, 0);

    report();
    $finish;
  end

endmodule